// File: doc/BRIEF.md
# USB IN Endpoint FIFO Controller

This block is the transmit-side FIFO of one USB IN endpoint. The local side pushes bytes into the FIFO. The USB side polls the block once per IN token, using a one-cycle token query. It receives either an acknowledge together with the length of the packet it may send, or a NAK. After an acknowledge it pulls that many bytes and marks the end of the packet with a one-cycle done pulse.

Release of a packet is governed by a control bit that selects between two modes. In the eager mode any queued data is offered. In the committed mode a packet goes out only when more bytes than the configured packet size are queued, or when software has set a valid bit. Setting that bit commits a short packet, or a zero-length packet when the FIFO is empty. The valid bit clears itself once a short packet has been sent.

A small register interface gives access to three things: the entry count, a control register with the mode bit and a self-clearing flush, and a status register. The status register holds the valid bit, sticky overflow and underflow flags that are cleared by writing 1, and the live full and empty bits.

Top module: `usb_in_ep_fifo`

## Requirements
- R1: Register address 0 reads the number of bytes held, from 0 to DEPTH. An accepted write adds one and an accepted read removes one.
- R2: Bytes leave on `rd_data` in the order they were written. `rd_data` is valid combinationally while `rd_en` is high and the FIFO is not empty.
- R3: A write while the FIFO is full is dropped and leaves the count at DEPTH. It sets the overflow flag (status bit 3), which stays set until a register write to address 2 has bit 3 at 1.
- R4: A read while the FIFO is empty returns 0 and changes nothing. It sets the underflow flag (status bit 2), which stays set until a register write to address 2 has bit 2 at 1.
- R5: A register write to address 1 with bit 0 at 1 empties the FIFO and clears the count and the valid bit. It wins over a data write or read in the same cycle. Control bit 0 always reads 0.
- R6: With the mode bit set (control bit 1), a token is acknowledged only when the count exceeds `max_pkt` or the valid bit is set. Otherwise it gets a NAK.
- R7: With the mode bit clear, a token is acknowledged when the FIFO is not empty or the valid bit is set. Otherwise it gets a NAK.
- R8: During a token, `pkt_len` equals the smaller of `max_pkt` and the count.
- R9: A register write to address 2 with bit 4 at 1 sets the valid bit (status bit 4). A `pkt_done` pulse clears it when fewer than `max_pkt` bytes were read since the previous done or flush. A full-size packet leaves it set.
- R10: After reset the status register reads 0x01 (empty only), and the control and count registers read 0.
- R11: Status bit 1 reads 1 exactly when the count is DEPTH. Status bit 0 reads 1 exactly when the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Local-side byte write |
| wr_data | input | 8 | Byte to write |
| rd_en | input | 1 | USB-side byte read |
| rd_data | output | 8 | Head byte, 0 when empty |
| pkt_done | input | 1 | End-of-packet pulse from the USB side |
| tok_valid | input | 1 | IN token query |
| tok_ack | output | 1 | Token answered with data |
| tok_nak | output | 1 | Token answered with NAK |
| pkt_len | output | 8 | Bytes to send for this token |
| max_pkt | input | 8 | Configured maximum packet size |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 count, 1 control, 2 status) |
| reg_wdata | input | 5 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |

## Verification
Directed sequences hold the token decision at the counts that separate the two modes. The count is set just below, equal to and above `max_pkt`, with the valid bit set or clear, and the FIFO empty for zero-length packets. Packets of exactly `max_pkt` bytes and shorter packets then tell the two outcomes of the valid bit's self-clear apart. A filled FIFO and a drained FIFO are pushed past their limits to separate dropped traffic from accepted traffic, and a flush is issued together with a write to show which one wins. Random traffic then alternates between phases biased towards writes and phases biased towards reads, with changing packet sizes and sporadic flushes, valid sets and flag clears. This covers the order of the data, the count and every token answer against a reference queue.

// File: rtl/usbep_pkg.sv
package usbep_pkg;
  localparam logic [1:0] ADDR_CNT = 2'd0;
  localparam logic [1:0] ADDR_CTL = 2'd1;
  localparam logic [1:0] ADDR_STS = 2'd2;

  localparam int CTL_FLUSH = 0;
  localparam int CTL_MODE  = 1;
  localparam int STS_EMPTY = 0;
  localparam int STS_FULL  = 1;
  localparam int STS_UNF   = 2;
  localparam int STS_OVF   = 3;
  localparam int STS_VALID = 4;

  localparam int REG_WW = 5;

  // bytes offered for one token
  function automatic int unsigned pkt_bytes(int unsigned cnt, int unsigned mx);
    return (cnt < mx) ? cnt : mx;
  endfunction

  // token answer: 1 = send data, 0 = NAK
  function automatic logic in_ready(logic mode, logic vbit,
                                    int unsigned cnt, int unsigned mx);
    if (vbit) return 1'b1;
    if (mode) return cnt > mx;
    return cnt != 0;
  endfunction
endpackage

// File: rtl/ep_fifo_store.sv
module ep_fifo_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          wr_drop,
  output logic          rd_drop,
  output logic          rd_take
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr_take;

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == FULLC);
  assign empty   = (count == '0);
  assign wr_take = wr_req & ~full & ~flush;
  assign rd_take = rd_req & ~empty & ~flush;
  assign wr_drop = wr_req & full & ~flush;
  assign rd_drop = rd_req & empty & ~flush;
  assign rd_data = empty ? '0 : mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_take) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_take) wptr <= bump(wptr);
      if (rd_take) rptr <= bump(rptr);
      case ({wr_take, rd_take})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_drop && !rd_req) |=> (count == FULLC));
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drop && !wr_req) |=> (count == '0));
  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/ep_in_resp.sv
module ep_in_resp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          tok_valid,
  input  logic          mode,
  input  logic          vbit,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] max_pkt,
  input  logic          rd_take,
  input  logic          pkt_done,
  output logic          tok_ack,
  output logic          tok_nak,
  output logic [CW-1:0] pkt_len,
  output logic          short_done
);
  import usbep_pkg::*;

  logic [CW-1:0] sent;
  logic          ready;

  assign ready      = in_ready(mode, vbit, 32'(count), 32'(max_pkt));
  assign tok_ack    = tok_valid & ready;
  assign tok_nak    = tok_valid & ~ready;
  assign pkt_len    = CW'(pkt_bytes(32'(count), 32'(max_pkt)));
  assign short_done = pkt_done & (sent < max_pkt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sent <= '0;
    else if (flush || pkt_done)  sent <= '0;
    else if (rd_take && sent != '1) sent <= sent + 1'b1;
  end

  always_comb begin
    if (rst_n && tok_valid)
      assert_len_bound_R8: assert (pkt_len <= max_pkt && pkt_len <= count);
  end

  assert_one_answer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tok_ack, tok_nak}));
  assert_answer_given_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tok_valid |-> (tok_ack || tok_nak));
endmodule

// File: rtl/ep_csr.sv
module ep_csr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [4:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [CW-1:0] count,
  input  logic          full,
  input  logic          empty,
  input  logic          wr_drop,
  input  logic          rd_drop,
  input  logic          short_done,
  output logic          flush,
  output logic          mode,
  output logic          vbit
);
  import usbep_pkg::*;

  logic ctl_wr, sts_wr, vset, ovf, unf, ovf_clr, unf_clr;

  assign ctl_wr  = reg_wr && reg_addr == ADDR_CTL;
  assign sts_wr  = reg_wr && reg_addr == ADDR_STS;
  assign flush   = ctl_wr & reg_wdata[CTL_FLUSH];
  assign vset    = sts_wr & reg_wdata[STS_VALID];
  assign ovf_clr = sts_wr & reg_wdata[STS_OVF];
  assign unf_clr = sts_wr & reg_wdata[STS_UNF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= 1'b0;
      vbit <= 1'b0;
      ovf  <= 1'b0;
      unf  <= 1'b0;
    end else begin
      if (ctl_wr) mode <= reg_wdata[CTL_MODE];
      if (flush)           vbit <= 1'b0;
      else if (vset)       vbit <= 1'b1;
      else if (short_done) vbit <= 1'b0;
      ovf <= wr_drop | (ovf & ~ovf_clr);
      unf <= rd_drop | (unf & ~unf_clr);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CNT: reg_rdata = 8'(count);
      ADDR_CTL: reg_rdata[CTL_MODE] = mode;
      ADDR_STS: begin
        reg_rdata[STS_VALID] = vbit;
        reg_rdata[STS_OVF]   = ovf;
        reg_rdata[STS_UNF]   = unf;
        reg_rdata[STS_FULL]  = full;
        reg_rdata[STS_EMPTY] = empty;
      end
      default: reg_rdata = '0;
    endcase
  end

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> ovf);
  assert_unf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_drop |=> unf);
  assert_flush_clears_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !vbit);
  assert_short_clears_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (short_done && !vset) |=> !vbit);
endmodule

// File: rtl/usb_in_ep_fifo.sv
module usb_in_ep_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          pkt_done,
  input  logic          tok_valid,
  output logic          tok_ack,
  output logic          tok_nak,
  output logic [7:0]    pkt_len,
  input  logic [7:0]    max_pkt,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [4:0]    reg_wdata,
  output logic [7:0]    reg_rdata
);
  localparam int CW = 8;

  logic [CW-1:0] count;
  logic full, empty, wr_drop, rd_drop, rd_take;
  logic flush, mode, vbit, short_done;

  ep_fifo_store #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_req(wr_en), .wr_data(wr_data), .rd_req(rd_en), .rd_data(rd_data),
    .count(count), .full(full), .empty(empty),
    .wr_drop(wr_drop), .rd_drop(rd_drop), .rd_take(rd_take)
  );

  ep_in_resp #(.CW(CW)) u_resp (
    .clk(clk), .rst_n(rst_n), .flush(flush), .tok_valid(tok_valid),
    .mode(mode), .vbit(vbit), .count(count), .max_pkt(max_pkt),
    .rd_take(rd_take), .pkt_done(pkt_done),
    .tok_ack(tok_ack), .tok_nak(tok_nak), .pkt_len(pkt_len),
    .short_done(short_done)
  );

  ep_csr #(.CW(CW)) u_csr (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(count), .full(full), .empty(empty),
    .wr_drop(wr_drop), .rd_drop(rd_drop), .short_done(short_done),
    .flush(flush), .mode(mode), .vbit(vbit)
  );

  initial begin
    assert_depth_fits_R1: assert (DEPTH >= 1 && DEPTH <= 255);
  end
endmodule

// File: tb/test_usb_in_ep_fifo.sv
module test_usb_in_ep_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 128;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, pkt_done = 0, tok_valid = 0, reg_wr = 0;
  logic [7:0] wr_data = 0, max_pkt = 8'd4;
  logic [1:0] reg_addr = 0;
  logic [4:0] reg_wdata = 0;
  logic [7:0] rd_data, pkt_len, reg_rdata;
  logic tok_ack, tok_nak;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_in_ep_fifo i_usb_in_ep_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pkt_done(pkt_done),
    .tok_valid(tok_valid), .tok_ack(tok_ack), .tok_nak(tok_nak),
    .pkt_len(pkt_len), .max_pkt(max_pkt), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  logic [7:0] q[$];
  bit m_mode = 0, m_vbit = 0, m_ovf = 0, m_unf = 0;
  int m_sent = 0;
  int last_rd, last_ack, last_len;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic int exp_reg(logic [1:0] a);
    case (a)
      2'd0: return q.size();
      2'd1: return int'(m_mode) << 1;
      2'd2: return (int'(m_vbit) << 4) | (int'(m_ovf) << 3) | (int'(m_unf) << 2) |
                   (int'(q.size() == DEPTH) << 1) | int'(q.size() == 0);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_ready();
    if (m_vbit) return 1;
    if (m_mode) return int'(q.size() > int'(max_pkt));
    return int'(q.size() != 0);
  endfunction

  function automatic int exp_len();
    return (q.size() < int'(max_pkt)) ? q.size() : int'(max_pkt);
  endfunction

  task automatic step(input bit w, input logic [7:0] wd, input bit r, input bit d,
                      input bit t, input bit rw, input logic [1:0] ra,
                      input logic [4:0] rwd);
    bit fl, vs, shrt, rtake, wtake;
    @(negedge clk);
    wr_en = w; wr_data = wd; rd_en = r; pkt_done = d; tok_valid = t;
    reg_wr = rw; reg_addr = ra; reg_wdata = rwd;
    #1;
    last_rd = int'(reg_rdata); last_ack = int'(tok_ack); last_len = int'(pkt_len);
    case (ra)
      2'd0: check("R1 count", int'(reg_rdata), exp_reg(ra));
      2'd1: check("R5 control", int'(reg_rdata), exp_reg(ra));
      2'd2: check("R11 status", int'(reg_rdata), exp_reg(ra));
      default: check("R1 unused", int'(reg_rdata), 0);
    endcase
    if (t) begin
      if (m_mode) check("R6 ack", int'(tok_ack), exp_ready());
      else        check("R7 ack", int'(tok_ack), exp_ready());
      check("R6 nak", int'(tok_nak), 1 - exp_ready());
      check("R8 len", int'(pkt_len), exp_len());
    end
    if (r) begin
      if (q.size() > 0) check("R2 data", int'(rd_data), int'(q[0]));
      else              check("R4 data", int'(rd_data), 0);
    end
    @(posedge clk);
    fl   = rw && ra == 2'd1 && rwd[0];
    vs   = rw && ra == 2'd2 && rwd[4];
    shrt = d && (m_sent < int'(max_pkt));
    rtake = r && !fl && q.size() > 0;
    wtake = w && !fl && q.size() < DEPTH;
    if (!fl) begin
      m_ovf = (w && q.size() == DEPTH) || (m_ovf && !(rw && ra == 2'd2 && rwd[3]));
      m_unf = (r && q.size() == 0)     || (m_unf && !(rw && ra == 2'd2 && rwd[2]));
    end
    if (rw && ra == 2'd1) m_mode = rwd[1];
    if (fl)        m_vbit = 0;
    else if (vs)   m_vbit = 1;
    else if (shrt) m_vbit = 0;
    if (fl || d) m_sent = 0;
    else if (rtake && m_sent != 255) m_sent++;
    if (fl) q.delete();
    else begin
      if (rtake) void'(q.pop_front());
      if (wtake) q.push_back(wd);
    end
  endtask

  task automatic idle(input logic [1:0] ra);
    step(0, 0, 0, 0, 0, 0, ra, 0);
  endtask
  task automatic push(input logic [7:0] b);
    step(1, b, 0, 0, 0, 0, 0, 0);
  endtask
  task automatic pull();
    step(0, 0, 1, 0, 0, 0, 0, 0);
  endtask
  task automatic tok();
    step(0, 0, 0, 0, 1, 0, 0, 0);
  endtask
  task automatic done();
    step(0, 0, 0, 1, 0, 0, 0, 0);
  endtask
  task automatic regw(input logic [1:0] a, input logic [4:0] v);
    step(0, 0, 0, 0, 0, 1, a, v);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R10 reset values
    idle(2); check("R10 status", last_rd, 8'h01);
    idle(1); check("R10 control", last_rd, 0);
    idle(0); check("R10 count", last_rd, 0);

    // committed mode, packet size 4
    max_pkt = 8'd4;
    regw(1, 5'b00010);
    for (int i = 0; i < 3; i++) push(8'(8'h10 + i));
    tok(); check("R6 nak below size", last_ack, 0);
    push(8'h13);
    tok(); check("R6 nak at size", last_ack, 0);
    push(8'h14);
    tok(); check("R6 ack above size", last_ack, 1); check("R8 len", last_len, 4);
    for (int i = 0; i < 4; i++) pull();
    done();
    regw(2, 5'b10000);
    tok(); check("R6 ack short", last_ack, 1); check("R8 short len", last_len, 1);
    pull(); done();
    idle(2); check("R9 valid cleared after short", last_rd, 8'h01);
    regw(2, 5'b10000);
    tok(); check("R6 zero length ack", last_ack, 1); check("R8 zero len", last_len, 0);
    done();
    idle(2); check("R9 valid cleared after zlp", last_rd, 8'h01);
    for (int i = 0; i < 4; i++) push(8'(8'h20 + i));
    regw(2, 5'b10000);
    for (int i = 0; i < 4; i++) pull();
    done();
    idle(2); check("R9 valid kept after full packet", last_rd, 8'h11);

    // eager mode
    regw(1, 5'b00000);
    tok(); check("R7 zero length via valid", last_ack, 1);
    regw(1, 5'b00001);
    idle(2); check("R5 flush clears valid", last_rd, 8'h01);
    tok(); check("R7 nak empty", last_ack, 0);
    push(8'h55);
    tok(); check("R7 ack one byte", last_ack, 1); check("R8 one byte", last_len, 1);
    regw(1, 5'b00001);

    // fill and overflow
    for (int i = 0; i < DEPTH; i++) push(8'(i * 3));
    push(8'hee);
    idle(0); check("R3 count held", last_rd, DEPTH);
    idle(2); check("R3 overflow flag", last_rd, 8'h0a);
    regw(2, 5'b01000);
    idle(2); check("R3 overflow cleared", last_rd, 8'h02);

    // drain and underflow
    for (int i = 0; i < DEPTH; i++) pull();
    pull();
    idle(0); check("R4 count held", last_rd, 0);
    idle(2); check("R4 underflow flag", last_rd, 8'h05);
    regw(2, 5'b00100);
    idle(2); check("R4 underflow cleared", last_rd, 8'h01);

    // flush against a same-cycle write
    for (int i = 0; i < 3; i++) push(8'(8'h70 + i));
    step(1, 8'h99, 0, 0, 0, 1, 1, 5'b00001);
    idle(0); check("R5 flush wins over write", last_rd, 0);
    idle(1); check("R5 flush bit reads 0", last_rd, 0);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit ph, w, r, d, t, rw;
      logic [1:0] ra;
      logic [4:0] rwd;
      if (i % 250 == 0) max_pkt = 8'(1 + $urandom % 32);
      ph = ((i / 300) % 2) == 0;
      w  = ($urandom % 100) < (ph ? 80 : 30);
      r  = ($urandom % 100) < (ph ? 30 : 80);
      d  = ($urandom % 100) < 10;
      t  = ($urandom % 100) < 30;
      rw = ($urandom % 100) < 5;
      ra = 2'($urandom % 3);
      rwd = 5'($urandom);
      if (rw && ra == 2'd1 && ($urandom % 4) != 0) rwd[0] = 1'b0;
      if (rw && ra == 2'd0) rw = 0;
      step(w, 8'($urandom), r, d, t, rw, ra, rwd);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule